// File: doc/BRIEF.md
# Receive Elastic Buffer with Correction-Sequence Add/Drop

This block sits between a receiver's recovered clock and the local user clock. Words enter on the write clock, each tagged as payload or as a one-word clock correction sequence. They leave on the read clock, one word per read cycle, whenever the buffer holds anything. The two clocks are unrelated, so their rates drift apart. The block makes up the difference by changing only the number of correction words, and it does so only where such a word sits in the stream. Payload words are never duplicated or deleted for rate matching.

When the write side sees the buffer at or above its high mark, an arriving correction word is dropped instead of stored. When the read side finds a correction word at the head while the buffer is at or below its low mark, it sends that word twice. Both events raise a one-cycle pulse in the read domain. A drop-all setting discards every correction word on arrival and never adds one, so a buffer that is fed slower than it is drained empties. A disable setting passes correction words through as ordinary words.

Top module: `rx_elastic_buf`

## Requirements
- R1: Payload words leave the read port in the order they were written, with none lost or repeated, as long as no word is turned away for lack of space.
- R2: With correction on and drop-all off, an arriving correction word is discarded when the write-side count of held words is HIGH (12) or more, and stored when it is HIGH-1 or less.
- R3: A word that arrives while 16 words are held is discarded, and `wr_overflow` pulses high for one write cycle in the cycle after the word arrived.
- R4: With correction on and drop-all off, a correction word at the head of the buffer is sent twice in a row when the read-side count is LOW (4) or less, and once when the count is LOW+1 or more.
- R5: `rd_ev_insert` is high for one read cycle together with each extra copy, and `rd_ev_remove` pulses once in the read domain for each discarded correction word, so the correction words sent equal those written plus inserts minus removes.
- R6: With drop-all on, every arriving correction word is discarded whatever the fill, none reaches the read port, and no copy is ever added.
- R7: With correction off, correction words pass through as ordinary words, once each, and neither event pulses.
- R8: When the read side finds the buffer empty, `rd_valid` is low and `rd_underflow` is high in the next read cycle.
- R9: During reset, `rd_valid`, `rd_underflow`, `rd_ev_insert`, `rd_ev_remove` and `wr_overflow` are all low.
- R10: Rate matching works in both directions. When the write clock is faster, removals occur and nothing overflows. When the read clock is faster, insertions occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| corr_enable | input | 1 | Enables rate matching with correction words; treated as static |
| drop_all | input | 1 | Discards every correction word and never inserts; treated as static |
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_valid | input | 1 | A word is presented this write cycle |
| wr_is_cc | input | 1 | The presented word is a correction word |
| wr_word | input | W | Presented word |
| wr_overflow | output | 1 | One-cycle pulse: a word was lost because the buffer was full |
| rd_clk | input | 1 | User (read) clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_valid | output | 1 | `rd_word` carries a word this read cycle |
| rd_is_cc | output | 1 | The word out is a correction word |
| rd_word | output | W | Word out |
| rd_ev_insert | output | 1 | One-cycle pulse alongside an added copy |
| rd_ev_remove | output | 1 | One-cycle pulse for each discarded correction word |
| rd_underflow | output | 1 | High in a read cycle that had nothing to send |

## Verification
A stored word reaches the read-side count after its write-clock pointer update and two read-clock synchronizer stages. From there it appears at the read port one read cycle after the head decision. An insert pulse comes with the second copy, two read cycles after the decision to repeat. A remove pulse follows the write-side toggle by three read-clock flops. An overflow pulse comes one write cycle after the lost word. Because these delays depend on the phase between the two clocks, the bench does not sample at predicted edges. It holds the read side in reset while it loads exact fill patterns. It then releases the read side, allows a drain of many read cycles, and compares the whole output stream and the event counts with values worked out from the thresholds. All sampling is done on falling edges.

// File: rtl/ebuf_pkg.sv
// Shared types for the receive elastic buffer.
// Assumes: nothing; holds only the per-side action encodings.
package ebuf_pkg;

    // What the write side does with the word presented this cycle.
    typedef enum logic [1:0] {
        WA_IDLE   = 2'd0,
        WA_STORE  = 2'd1,
        WA_REMOVE = 2'd2,
        WA_LOSE   = 2'd3
    } wr_act_e;

    // What the read side does with the head entry this cycle.
    typedef enum logic [1:0] {
        RA_STARVE = 2'd0,
        RA_STEP   = 2'd1,
        RA_REPEAT = 2'd2
    } rd_act_e;

endpackage

// File: rtl/ebuf_ptr_sync.sv
// Carries a Gray-coded pointer into another clock domain through two
// flops and returns it in binary form.
// Assumes: the source is a register that changes at most one bit per
// source clock, so every sampled value is a valid pointer.
module ebuf_ptr_sync #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] src_gray,
    output logic [PW-1:0] dst_bin
);

    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    // Two-stage capture of the foreign pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= src_gray;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the parity of itself and all bits above.
    for (genvar g = 0; g < PW; g++) begin : g_g2b
        assign dst_bin[g] = ^sync_q[PW-1:g];
    end

endmodule

// File: rtl/ebuf_wr_ctrl.sv
// Write side of the elastic buffer. It decides per presented word to
// store it, discard it as a surplus correction word, or lose it for lack
// of space. It owns the write pointer and its Gray copy.
// Assumes: rd_ptr_bin is the read pointer already synchronized into this
// domain; corr_en and drop_all are static while out of reset.
module ebuf_wr_ctrl
    import ebuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int HIGH  = 12,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_is_cc,
    input  logic          corr_en,
    input  logic          drop_all,
    input  logic [PW-1:0] rd_ptr_bin,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] wr_gray,
    output logic          rm_toggle,
    output logic          overflow
);

    localparam logic [PW-1:0] HIGH_V = PW'(HIGH);
    localparam logic [PW-1:0] FULL_V = PW'(DEPTH);

    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] ptr_nxt;
    logic [PW-1:0] fill;
    wr_act_e       act;

    assign fill = wr_ptr - rd_ptr_bin;

    // Per-word decision: surplus correction words go first, then space check.
    always_comb begin
        act = WA_IDLE;
        if (in_valid) begin
            if (in_is_cc && corr_en && (drop_all || fill >= HIGH_V))
                act = WA_REMOVE;
            else if (fill == FULL_V)
                act = WA_LOSE;
            else
                act = WA_STORE;
        end
    end

    assign ptr_nxt  = (act == WA_STORE) ? wr_ptr + PW'(1) : wr_ptr;
    assign mem_we   = (act == WA_STORE);
    assign mem_addr = wr_ptr[AW-1:0];

    // Pointer, its Gray image, removal toggle and loss pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            wr_gray   <= '0;
            rm_toggle <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            wr_ptr    <= ptr_nxt;
            wr_gray   <= ptr_nxt ^ (ptr_nxt >> 1);
            rm_toggle <= rm_toggle ^ (act == WA_REMOVE);
            overflow  <= (act == WA_LOSE);
        end
    end

    // R3: a lost word never moves the pointer.
    p_ptr_frozen_on_loss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $stable(wr_ptr))
        else $error("write pointer moved on a lost word");

    // R3: the write-side count never exceeds the depth.
    p_fill_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL_V)
        else $error("write-side fill above depth");

    // R1: the crossing pointer changes by at most one bit per cycle.
    p_gray_one_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1)
        else $error("gray write pointer jumped");

    // R2: a removal only follows an offered correction word with correction on.
    p_remove_only_cc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rm_toggle) |-> $past(in_valid && in_is_cc && corr_en))
        else $error("removal without a correction word");

endmodule

// File: rtl/ebuf_rd_ctrl.sv
// Read side of the elastic buffer. Each read cycle it sends the head
// entry, steps past it, or sends a correction word a second time when
// the buffer runs low. It also turns the write-side removal toggle into
// a read-domain pulse.
// Assumes: wr_ptr_bin is already synchronized into this domain; the
// removal toggle flips at most once per read cycle; config is static.
module ebuf_rd_ctrl
    import ebuf_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int LOW   = 4,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          corr_en,
    input  logic          drop_all,
    input  logic [PW-1:0] wr_ptr_bin,
    input  logic [W-1:0]  ent_word,
    input  logic          ent_cc,
    input  logic          rm_toggle_src,
    output logic [AW-1:0] rd_addr,
    output logic [PW-1:0] rd_gray,
    output logic [W-1:0]  out_word,
    output logic          out_cc,
    output logic          out_valid,
    output logic          ev_insert,
    output logic          ev_remove,
    output logic          underflow
);

    localparam logic [PW-1:0] LOW_V = PW'(LOW);

    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] ptr_nxt;
    logic [PW-1:0] fill;
    logic          repeat_hold;
    logic [2:0]    rm_sync;
    rd_act_e       act;

    assign fill    = wr_ptr_bin - rd_ptr;
    assign rd_addr = rd_ptr[AW-1:0];

    // Head decision: starve on empty, repeat a low-fill correction word once.
    always_comb begin
        if (fill == '0)
            act = RA_STARVE;
        else if (ent_cc && corr_en && !drop_all && fill <= LOW_V && !repeat_hold)
            act = RA_REPEAT;
        else
            act = RA_STEP;
    end

    assign ptr_nxt = (act == RA_STEP) ? rd_ptr + PW'(1) : rd_ptr;

    // Output register, pointer, repeat marker and insert pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr      <= '0;
            rd_gray     <= '0;
            out_word    <= '0;
            out_cc      <= 1'b0;
            out_valid   <= 1'b0;
            underflow   <= 1'b0;
            repeat_hold <= 1'b0;
            ev_insert   <= 1'b0;
        end else begin
            rd_ptr    <= ptr_nxt;
            rd_gray   <= ptr_nxt ^ (ptr_nxt >> 1);
            out_valid <= (act != RA_STARVE);
            underflow <= (act == RA_STARVE);
            ev_insert <= (act == RA_STEP) && repeat_hold;
            if (act != RA_STARVE) begin
                out_word <= ent_word;
                out_cc   <= ent_cc;
            end
            if (act == RA_REPEAT)
                repeat_hold <= 1'b1;
            else if (act == RA_STEP)
                repeat_hold <= 1'b0;
        end
    end

    // Three-flop capture of the removal toggle; an edge is one removal.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rm_sync <= '0;
        else
            rm_sync <= {rm_sync[1:0], rm_toggle_src};
    end

    assign ev_remove = rm_sync[2] ^ rm_sync[1];

    // R4: an insert pulse comes with a second identical correction word.
    p_insert_repeats_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_insert |-> (out_valid && out_cc && $past(out_valid) && $past(out_cc)
                       && out_word == $past(out_word)))
        else $error("insert pulse without a repeated correction word");

    // R4: a correction word is repeated at most once.
    p_hold_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_hold |=> !repeat_hold)
        else $error("correction word repeated more than once");

    // R8: an empty slot never carries a word.
    p_underflow_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> !out_valid)
        else $error("underflow with valid output");

    // R6: drop-all never produces an insertion.
    p_no_insert_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_all && $past(drop_all) && $past(drop_all, 2)) |-> !ev_insert)
        else $error("insertion in drop-all mode");

endmodule

// File: rtl/rx_elastic_buf.sv
// Dual-clock receive elastic buffer that matches rates by discarding or
// repeating single-word clock correction sequences where they occur.
// Assumes: corr_enable and drop_all are static while either side runs;
// DEPTH is a power of two; LOW < HIGH <= DEPTH; the read clock samples
// each flip of the removal toggle (clocks of comparable rate).
module rx_elastic_buf #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int HIGH  = 12,
    parameter int LOW   = 4
) (
    input  logic         corr_enable,
    input  logic         drop_all,
    input  logic         wr_clk,
    input  logic         wr_rst_n,
    input  logic         wr_valid,
    input  logic         wr_is_cc,
    input  logic [W-1:0] wr_word,
    output logic         wr_overflow,
    input  logic         rd_clk,
    input  logic         rd_rst_n,
    output logic         rd_valid,
    output logic         rd_is_cc,
    output logic [W-1:0] rd_word,
    output logic         rd_ev_insert,
    output logic         rd_ev_remove,
    output logic         rd_underflow
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [W:0]    store [DEPTH];
    logic          mem_we;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [PW-1:0] wr_gray;
    logic [PW-1:0] rd_gray;
    logic [PW-1:0] wr_ptr_in_rd;
    logic [PW-1:0] rd_ptr_in_wr;
    logic          rm_toggle;
    logic [W:0]    head;

    ebuf_wr_ctrl #(.DEPTH(DEPTH), .HIGH(HIGH), .AW(AW), .PW(PW)) u_wr (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .in_valid   (wr_valid),
        .in_is_cc   (wr_is_cc),
        .corr_en    (corr_enable),
        .drop_all   (drop_all),
        .rd_ptr_bin (rd_ptr_in_wr),
        .mem_we     (mem_we),
        .mem_addr   (wr_addr),
        .wr_gray    (wr_gray),
        .rm_toggle  (rm_toggle),
        .overflow   (wr_overflow)
    );

    // Storage holds only data already guarded by pointers, so it has no reset.
    always_ff @(posedge wr_clk) begin
        if (mem_we)
            store[wr_addr] <= {wr_is_cc, wr_word};
    end

    assign head = store[rd_addr];

    ebuf_ptr_sync #(.PW(PW)) u_wsync (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .src_gray (wr_gray),
        .dst_bin  (wr_ptr_in_rd)
    );

    ebuf_ptr_sync #(.PW(PW)) u_rsync (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .src_gray (rd_gray),
        .dst_bin  (rd_ptr_in_wr)
    );

    ebuf_rd_ctrl #(.W(W), .DEPTH(DEPTH), .LOW(LOW), .AW(AW), .PW(PW)) u_rd (
        .clk           (rd_clk),
        .rst_n         (rd_rst_n),
        .corr_en       (corr_enable),
        .drop_all      (drop_all),
        .wr_ptr_bin    (wr_ptr_in_rd),
        .ent_word      (head[W-1:0]),
        .ent_cc        (head[W]),
        .rm_toggle_src (rm_toggle),
        .rd_addr       (rd_addr),
        .rd_gray       (rd_gray),
        .out_word      (rd_word),
        .out_cc        (rd_is_cc),
        .out_valid     (rd_valid),
        .ev_insert     (rd_ev_insert),
        .ev_remove     (rd_ev_remove),
        .underflow     (rd_underflow)
    );

endmodule

// File: tb/sim_rx_elastic_buf.sv
`timescale 1ns/1ps
module sim_rx_elastic_buf;

    localparam int W     = 16;
    localparam int DEPTH = 16;
    localparam int HIGH  = 12;
    localparam int LOW   = 4;
    localparam logic [W-1:0] CC_VAL = 16'hBC50;

    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    real  rd_half = 5.0;

    logic         corr_enable = 1'b1;
    logic         drop_all = 1'b0;
    logic         wr_rst_n = 1'b0;
    logic         rd_rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic         wr_is_cc = 1'b0;
    logic [W-1:0] wr_word = '0;
    logic         wr_overflow;
    logic         rd_valid, rd_is_cc, rd_ev_insert, rd_ev_remove, rd_underflow;
    logic [W-1:0] rd_word;

    always #5 wr_clk = ~wr_clk;
    initial forever #(rd_half) rd_clk = ~rd_clk;

    rx_elastic_buf #(.W(W), .DEPTH(DEPTH), .HIGH(HIGH), .LOW(LOW)) u0 (
        .corr_enable (corr_enable), .drop_all (drop_all),
        .wr_clk (wr_clk), .wr_rst_n (wr_rst_n), .wr_valid (wr_valid),
        .wr_is_cc (wr_is_cc), .wr_word (wr_word), .wr_overflow (wr_overflow),
        .rd_clk (rd_clk), .rd_rst_n (rd_rst_n), .rd_valid (rd_valid),
        .rd_is_cc (rd_is_cc), .rd_word (rd_word), .rd_ev_insert (rd_ev_insert),
        .rd_ev_remove (rd_ev_remove), .rd_underflow (rd_underflow)
    );

    int checks = 0;
    int errors = 0;
    int ins_cnt = 0;
    int rm_cnt = 0;
    int ovf_cnt = 0;
    bit done = 1'b0;
    logic [W:0] obs_q[$];
    logic [W:0] exp_q[$];

    // Collect outputs and events away from the active edges.
    always @(negedge rd_clk) begin
        if (rd_valid) obs_q.push_back({rd_is_cc, rd_word});
        if (rd_ev_insert) ins_cnt++;
        if (rd_ev_remove) rm_cnt++;
    end

    always @(negedge wr_clk) begin
        if (wr_overflow) ovf_cnt++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit hold_rd);
        wr_valid = 1'b0;
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        repeat (6) @(negedge wr_clk);
        wr_rst_n = 1'b1;
        if (!hold_rd) begin
            @(negedge rd_clk);
            rd_rst_n = 1'b1;
        end
        obs_q.delete();
        exp_q.delete();
        ins_cnt = 0;
        rm_cnt  = 0;
        ovf_cnt = 0;
    endtask

    task automatic send(input bit cc, input logic [W-1:0] v, input int copies);
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_is_cc = cc;
        wr_word  = v;
        for (int k = 0; k < copies; k++) exp_q.push_back({cc, v});
    endtask

    task automatic go_idle();
        @(negedge wr_clk);
        wr_valid = 1'b0;
    endtask

    // Release the held read side, drain, and compare the whole stream.
    task automatic finish_directed(input string req);
        int mism;
        go_idle();
        repeat (4) @(negedge wr_clk);
        @(negedge rd_clk);
        rd_rst_n = 1'b1;
        repeat (60) @(negedge rd_clk);
        check(obs_q.size() == exp_q.size(), req, "output length", obs_q.size(), exp_q.size());
        mism = -1;
        for (int i = 0; i < obs_q.size() && i < exp_q.size(); i++)
            if (obs_q[i] !== exp_q[i] && mism < 0) mism = i;
        check(mism < 0, req, "first mismatching output index", mism, -1);
        // R8: once drained, the read port reports an empty slot.
        check(rd_valid == 1'b0 && rd_underflow == 1'b1, "R8", "empty valid/underflow",
              {rd_valid, rd_underflow}, 1);
    endtask

    // Continuous stream with a correction word every `every` words.
    task automatic stream(input int n, input int every, output int d_in, output int c_in);
        d_in = 0;
        c_in = 0;
        for (int i = 0; i < n; i++) begin
            if (i % every == every - 1) begin
                send(1'b1, CC_VAL, 0);
                c_in++;
            end else begin
                send(1'b0, W'(d_in), 0);
                d_in++;
            end
        end
        go_idle();
        repeat (300) @(negedge rd_clk);
    endtask

    // Count data words in exact order and correction words seen.
    task automatic tally(output int d_bad, output int d_out, output int c_out);
        d_bad = 0;
        d_out = 0;
        c_out = 0;
        for (int i = 0; i < obs_q.size(); i++) begin
            if (obs_q[i][W]) begin
                c_out++;
                if (obs_q[i][W-1:0] != CC_VAL) d_bad++;
            end else begin
                if (obs_q[i][W-1:0] != W'(d_out)) d_bad++;
                d_out++;
            end
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int d_in, c_in, d_bad, d_out, c_out, prev, incr_bad;

        // R9: reset state.
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        repeat (6) @(negedge wr_clk);
        check({rd_valid, rd_underflow, rd_ev_insert, rd_ev_remove, wr_overflow} == 5'b0,
              "R9", "outputs in reset",
              {rd_valid, rd_underflow, rd_ev_insert, rd_ev_remove, wr_overflow}, 0);

        // R2/R3: load with read held: CC stored at fill 11, removed at 12, loss at 16.
        corr_enable = 1'b1; drop_all = 1'b0;
        do_reset(1'b1);
        for (int i = 0; i < 11; i++) send(1'b0, W'(i), 1);
        send(1'b1, CC_VAL, 1);
        send(1'b1, CC_VAL, 0);
        for (int i = 11; i < 15; i++) send(1'b0, W'(i), 1);
        send(1'b0, W'(15), 0);
        finish_directed("R2");
        check(ovf_cnt == 1, "R3", "overflow pulses", ovf_cnt, 1);
        check(rm_cnt == 1, "R5", "remove pulses", rm_cnt, 1);
        check(ins_cnt == 0, "R4", "insert at fill LOW+1", ins_cnt, 0);

        // R4: CC at head with read fill exactly LOW is sent twice.
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) send(1'b0, W'(i), 1);
        send(1'b1, CC_VAL, 2);
        for (int i = 4; i < 7; i++) send(1'b0, W'(i), 1);
        finish_directed("R4");
        check(ins_cnt == 1, "R5", "insert pulses at fill LOW", ins_cnt, 1);
        check(ovf_cnt == 0, "R3", "no overflow below depth", ovf_cnt, 0);

        // R4: CC at head with read fill LOW+1 is sent once.
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) send(1'b0, W'(i), 1);
        send(1'b1, CC_VAL, 1);
        for (int i = 4; i < 8; i++) send(1'b0, W'(i), 1);
        finish_directed("R4");
        check(ins_cnt == 0, "R4", "insert pulses at fill LOW+1", ins_cnt, 0);

        // R6: drop-all discards a CC at low fill.
        drop_all = 1'b1;
        do_reset(1'b1);
        send(1'b0, W'(0), 1);
        send(1'b1, CC_VAL, 0);
        send(1'b0, W'(1), 1);
        send(1'b0, W'(2), 1);
        finish_directed("R6");
        check(rm_cnt == 1 && ins_cnt == 0, "R6", "drop-all remove/insert", rm_cnt * 10 + ins_cnt, 10);

        // R7: correction off keeps CCs at and above HIGH and at low fill.
        corr_enable = 1'b0; drop_all = 1'b0;
        do_reset(1'b1);
        for (int i = 0; i < 12; i++) send(1'b0, W'(i), 1);
        send(1'b1, CC_VAL, 1);
        send(1'b1, CC_VAL, 1);
        send(1'b0, W'(12), 1);
        send(1'b0, W'(13), 1);
        finish_directed("R7");
        check(rm_cnt == 0 && ins_cnt == 0, "R7", "events with correction off", rm_cnt + ins_cnt, 0);

        // R10: write clock faster: removals, no overflow, exact order.
        corr_enable = 1'b1; drop_all = 1'b0; rd_half = 5.5;
        do_reset(1'b0);
        stream(400, 4, d_in, c_in);
        tally(d_bad, d_out, c_out);
        check(d_bad == 0 && d_out == d_in, "R1", "payload order (write faster)", d_out, d_in);
        check(rm_cnt > 0, "R10", "removals with write faster", rm_cnt, 1);
        check(ovf_cnt == 0, "R10", "overflow with write faster", ovf_cnt, 0);
        check(c_out == c_in + ins_cnt - rm_cnt, "R5", "CC accounting (write faster)",
              c_out, c_in + ins_cnt - rm_cnt);

        // R10: read clock faster: insertions, exact order.
        rd_half = 4.5;
        do_reset(1'b0);
        stream(400, 4, d_in, c_in);
        tally(d_bad, d_out, c_out);
        check(d_bad == 0 && d_out == d_in, "R1", "payload order (read faster)", d_out, d_in);
        check(ins_cnt > 0, "R10", "insertions with read faster", ins_cnt, 1);
        check(c_out == c_in + ins_cnt - rm_cnt, "R5", "CC accounting (read faster)",
              c_out, c_in + ins_cnt - rm_cnt);

        // R7: correction off over a stream.
        corr_enable = 1'b0;
        do_reset(1'b0);
        stream(300, 5, d_in, c_in);
        tally(d_bad, d_out, c_out);
        check(d_bad == 0 && d_out == d_in, "R7", "payload order (correction off)", d_out, d_in);
        check(c_out == c_in && ins_cnt == 0 && rm_cnt == 0, "R7", "CC pass-through count", c_out, c_in);

        // R6: drop-all over a stream.
        corr_enable = 1'b1; drop_all = 1'b1;
        do_reset(1'b0);
        stream(300, 4, d_in, c_in);
        tally(d_bad, d_out, c_out);
        check(d_bad == 0 && d_out == d_in, "R6", "payload order (drop-all)", d_out, d_in);
        check(c_out == 0 && ins_cnt == 0, "R6", "CCs out in drop-all", c_out + ins_cnt, 0);
        check(rm_cnt == c_in, "R6", "removals equal CCs in", rm_cnt, c_in);

        // R3: correction off, read at half rate: words are lost, order kept.
        corr_enable = 1'b0; drop_all = 1'b0; rd_half = 10.0;
        do_reset(1'b0);
        for (int i = 0; i < 200; i++) send(1'b0, W'(i), 0);
        go_idle();
        repeat (100) @(negedge rd_clk);
        prev = -1;
        incr_bad = 0;
        for (int i = 0; i < obs_q.size(); i++) begin
            if (int'(obs_q[i][W-1:0]) <= prev) incr_bad++;
            prev = int'(obs_q[i][W-1:0]);
        end
        check(ovf_cnt > 0, "R3", "overflow pulses at half read rate", ovf_cnt, 1);
        check(obs_q.size() + ovf_cnt == 200, "R3", "words out plus words lost",
              obs_q.size() + ovf_cnt, 200);
        check(incr_bad == 0, "R3", "order violations after loss", incr_bad, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule